// File: doc/BRIEF.md
# Push Button Power Sequencing Controller

This block decides when a system's main supply is switched on and off. The only turn-on source is an active-low push button. Once the system is up, three things can take the supply down. A processor can pull its kill line low. The button can be pressed, and so can an active-low undervoltage flag; either one first raises a power-down interrupt to the processor and then, if it is held long enough, forces the supply off without any help from the processor. Analog comparators and the capacitor-timed oscillator stay outside the block. They arrive as level inputs plus a single-cycle strobe, `pdt_tick`.

All millisecond timing comes from a 1 kHz tick, which a prescaler derives from the system clock. The button, undervoltage and kill inputs each pass through two flops before use. After the supply comes up there is a blanking window during which every input is ignored. At the end of that window the processor must be holding kill high, or the power-on attempt is abandoned. After any release of the enable there is a lockout period before the next turn-on can begin.

Top module: `pbc_top`

## Requirements
- R1: After reset, enable is inactive and `int_n` is 1. With `EN_ACTIVE_HIGH`=1 the inactive enable level is 0.
- R2: While power is off, `pb_n` must stay low without a break for `DEB_MS` ticks before enable is asserted. A shorter press leaves enable inactive.
- R3: While power is off and `uv_n` is low, a button press of any length leaves enable inactive.
- R4: For `BLANK_MS` ticks after enable is asserted, enable stays asserted and `int_n` stays 1, whatever `kill_n`, `pb_n` and `uv_n` do.
- R5: When the blanking window ends, enable is released if `kill_n` is low; if `kill_n` is high, enable stays asserted.
- R6: Once blanking is over and power is on, `kill_n` low releases enable within a few clocks. This also applies while an interrupt is pending.
- R7: While power is on and blanking is over, holding `pb_n` or `uv_n` low for `DEB_MS` ticks drives `int_n` to 0. `int_n` stays 0 for as long as that input stays low, and `int_n` is never 0 while enable is inactive.
- R8: Once asserted, `int_n` stays 0 for at least `INT_MIN_MS` ticks, even if the input that started it is released earlier.
- R9: The first input to go low (the button, if both go low in the same cycle) owns the power-down sequence. The other input is ignored until the owner is released and the interrupt has ended, or until the sequence completes. A later sequence started by the other input times from its own start.
- R10: If the owning input stays low for `FIXED_MS` ticks and then for `PDT_CYCLES` further `pdt_tick` strobes, enable and interrupt are both released in the same cycle.
- R11: If no `pdt_tick` has been seen for `PDT_IDLE_MS` ticks, the extra delay is taken as zero, so a forced power-off happens after `FIXED_MS` ticks alone.
- R12: After enable is released it stays inactive for at least `LOCK_MS` ticks. A button press that is still held when that period ends must be released before a new turn-on can start.
- R13: With `EN_ACTIVE_HIGH`=1, `en_out` is 1 when power is on. With `EN_ACTIVE_HIGH`=0, `en_out` is 0 when power is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pb_n | input | 1 | Push button, active low, asynchronous |
| uv_n | input | 1 | Undervoltage flag, active low, asynchronous |
| kill_n | input | 1 | Processor power-kill request, active low, asynchronous |
| pdt_tick | input | 1 | Power-down timer strobe, one clock wide, synchronous to clk |
| en_out | output | 1 | Supply enable, polarity set by EN_ACTIVE_HIGH |
| int_n | output | 1 | Power-down interrupt to the processor, active low |

## Verification
The bench drives a small configuration where one millisecond is four clocks. It sets each check point a margin away from the edge of its timing window. One test lets the button go in the middle of the interrupt; a design that tied the interrupt to the button level would end the pulse early. Another pulls the undervoltage flag low while the button owns the sequence; a design without ownership would count the flag's hold time from the moment it fell and would switch power off several milliseconds too soon. A further test turns the timer strobe off; a design that kept waiting for strobes would never complete the forced power-off. A press held across the lockout must not turn the system back on, and one test checks exactly that. A second instance with the opposite enable polarity is compared against the first at every enable check.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_ON_DEB   = 3'd1,
    ST_BLANK    = 3'd2,
    ST_RUN      = 3'd3,
    ST_OFF_DEB  = 3'd4,
    ST_INT_HOLD = 3'd5,
    ST_INT_TAIL = 3'd6,
    ST_LOCKOUT  = 3'd7
  } pbc_state_e;

  typedef enum logic {
    OWN_PB = 1'b0,
    OWN_UV = 1'b1
  } pbc_owner_e;

  function automatic logic st_powered(pbc_state_e s);
    return (s == ST_BLANK) || (s == ST_RUN) || (s == ST_OFF_DEB) ||
           (s == ST_INT_HOLD) || (s == ST_INT_TAIL);
  endfunction

  function automatic logic st_irq(pbc_state_e s);
    return (s == ST_INT_HOLD) || (s == ST_INT_TAIL);
  endfunction

endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end

    assign q[i] = sync_q;
  end

endmodule

// File: rtl/pbc_prescale.sv
module pbc_prescale #(
  parameter int PRESCALE = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ms_tick
);

  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;

  assign ms_tick = (cnt_q == P_LAST);

  always_comb begin
    if (ms_tick) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pbc_pdt_mon.sv
module pbc_pdt_mon #(
  parameter int IDLE_MS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pdt_tick,
  output logic tick_alive
);

  localparam int IW = $clog2(IDLE_MS + 1);
  localparam logic [IW-1:0] I_SAT = IW'(IDLE_MS);

  logic [IW-1:0] idle_q;
  logic [IW-1:0] idle_d;

  always_comb begin
    idle_d = idle_q;
    if (pdt_tick)                     idle_d = '0;
    else if (ms_tick && idle_q != I_SAT) idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= I_SAT;
    else        idle_q <= idle_d;
  end

  assign tick_alive = (idle_q != I_SAT);

endmodule

// File: rtl/pbc_fsm.sv
module pbc_fsm
  import pbc_pkg::*;
#(
  parameter int DEB_MS     = 32,
  parameter int BLANK_MS   = 512,
  parameter int FIXED_MS   = 64,
  parameter int LOCK_MS    = 64,
  parameter int INT_MIN_MS = 32,
  parameter int PDT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pb_low,
  input  logic uv_low,
  input  logic kill_low,
  input  logic pdt_tick,
  input  logic tick_alive,
  output logic en_act,
  output logic irq_act
);

  localparam int M1   = (DEB_MS > BLANK_MS) ? DEB_MS : BLANK_MS;
  localparam int M2   = (FIXED_MS > LOCK_MS) ? FIXED_MS : LOCK_MS;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = $clog2(INT_MIN_MS + 1);
  localparam int PCW  = $clog2(PDT_CYCLES + 1);

  localparam logic [TW-1:0]  T_DEB_LAST   = TW'(DEB_MS - 1);
  localparam logic [TW-1:0]  T_BLANK_LAST = TW'(BLANK_MS - 1);
  localparam logic [TW-1:0]  T_FIXED      = TW'(FIXED_MS);
  localparam logic [TW-1:0]  T_LOCK       = TW'(LOCK_MS);
  localparam logic [TW-1:0]  T_SAT        = TW'(TMAX);
  localparam logic [IW-1:0]  I_MIN        = IW'(INT_MIN_MS);
  localparam logic [PCW-1:0] P_LAST       = PCW'(PDT_CYCLES - 1);

  pbc_state_e     st_q,   st_d;
  pbc_owner_e     own_q,  own_d;
  logic [TW-1:0]  tcnt_q, tcnt_d, tcnt_inc;
  logic [IW-1:0]  icnt_q, icnt_d, icnt_inc;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           en_q, irq_q;
  logic           owner_low;
  logic           fixed_done;
  logic           pdt_done;

  assign owner_low  = (own_q == OWN_PB) ? pb_low : uv_low;
  assign tcnt_inc   = (ms_tick && tcnt_q != T_SAT) ? tcnt_q + 1'b1 : tcnt_q;
  assign icnt_inc   = (ms_tick && icnt_q != I_MIN) ? icnt_q + 1'b1 : icnt_q;
  assign fixed_done = (tcnt_q >= T_FIXED);
  assign pdt_done   = (pdt_tick && pcnt_q == P_LAST) || !tick_alive;

  always_comb begin
    st_d   = st_q;
    own_d  = own_q;
    tcnt_d = tcnt_inc;
    icnt_d = icnt_inc;
    pcnt_d = pcnt_q;
    unique case (st_q)
      ST_OFF: begin
        tcnt_d = '0;
        if (pb_low && !uv_low) st_d = ST_ON_DEB;
      end
      ST_ON_DEB: begin
        if (!pb_low || uv_low) begin
          st_d   = ST_OFF;
          tcnt_d = '0;
        end else if (ms_tick && tcnt_q == T_DEB_LAST) begin
          st_d   = ST_BLANK;
          tcnt_d = '0;
        end
      end
      ST_BLANK: begin
        if (ms_tick && tcnt_q == T_BLANK_LAST) begin
          st_d   = kill_low ? ST_LOCKOUT : ST_RUN;
          tcnt_d = '0;
        end
      end
      ST_RUN: begin
        tcnt_d = '0;
        icnt_d = '0;
        pcnt_d = '0;
        if (kill_low) begin
          st_d = ST_LOCKOUT;
        end else if (pb_low) begin
          st_d  = ST_OFF_DEB;
          own_d = OWN_PB;
        end else if (uv_low) begin
          st_d  = ST_OFF_DEB;
          own_d = OWN_UV;
        end
      end
      ST_OFF_DEB: begin
        if (kill_low) begin
          st_d   = ST_LOCKOUT;
          tcnt_d = '0;
        end else if (!owner_low) begin
          st_d   = ST_RUN;
          tcnt_d = '0;
        end else if (ms_tick && tcnt_q == T_DEB_LAST) begin
          st_d   = ST_INT_HOLD;
          icnt_d = '0;
        end
      end
      ST_INT_HOLD: begin
        if (kill_low) begin
          st_d   = ST_LOCKOUT;
          tcnt_d = '0;
        end else if (!owner_low) begin
          st_d   = (icnt_q >= I_MIN) ? ST_RUN : ST_INT_TAIL;
          tcnt_d = '0;
        end else if (fixed_done) begin
          if (pdt_done) begin
            st_d   = ST_LOCKOUT;
            tcnt_d = '0;
          end else if (pdt_tick) begin
            pcnt_d = pcnt_q + 1'b1;
          end
        end
      end
      ST_INT_TAIL: begin
        tcnt_d = '0;
        if (kill_low)               st_d = ST_LOCKOUT;
        else if (icnt_q >= I_MIN)   st_d = ST_RUN;
      end
      ST_LOCKOUT: begin
        if (tcnt_q >= T_LOCK && !pb_low) begin
          st_d   = ST_OFF;
          tcnt_d = '0;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      own_q  <= OWN_PB;
      tcnt_q <= '0;
      icnt_q <= '0;
      pcnt_q <= '0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      own_q  <= own_d;
      tcnt_q <= tcnt_d;
      icnt_q <= icnt_d;
      pcnt_q <= pcnt_d;
      en_q   <= st_powered(st_d);
      irq_q  <= st_irq(st_d);
    end
  end

  assign en_act  = en_q;
  assign irq_act = irq_q;

endmodule

// File: rtl/pbc_top.sv
module pbc_top #(
  parameter int PRESCALE       = 50000,
  parameter int DEB_MS         = 32,
  parameter int BLANK_MS       = 512,
  parameter int FIXED_MS       = 64,
  parameter int LOCK_MS        = 64,
  parameter int INT_MIN_MS     = 32,
  parameter int PDT_CYCLES     = 16,
  parameter int PDT_IDLE_MS    = 8,
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pb_n,
  input  logic uv_n,
  input  logic kill_n,
  input  logic pdt_tick,
  output logic en_out,
  output logic int_n
);

  logic [2:0] raw_in;
  logic [2:0] sync_in;
  logic       pb_low, uv_low, kill_low;
  logic       ms_tick;
  logic       tick_alive;
  logic       en_act, irq_act;

  assign raw_in = {kill_n, uv_n, pb_n};

  pbc_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  assign pb_low   = ~sync_in[0];
  assign uv_low   = ~sync_in[1];
  assign kill_low = ~sync_in[2];

  pbc_prescale #(.PRESCALE(PRESCALE)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick)
  );

  pbc_pdt_mon #(.IDLE_MS(PDT_IDLE_MS)) u_pdt_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .pdt_tick   (pdt_tick),
    .tick_alive (tick_alive)
  );

  pbc_fsm #(
    .DEB_MS     (DEB_MS),
    .BLANK_MS   (BLANK_MS),
    .FIXED_MS   (FIXED_MS),
    .LOCK_MS    (LOCK_MS),
    .INT_MIN_MS (INT_MIN_MS),
    .PDT_CYCLES (PDT_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .pb_low     (pb_low),
    .uv_low     (uv_low),
    .kill_low   (kill_low),
    .pdt_tick   (pdt_tick),
    .tick_alive (tick_alive),
    .en_act     (en_act),
    .irq_act    (irq_act)
  );

  if (EN_ACTIVE_HIGH) begin : g_en_pos
    assign en_out = en_act;
  end else begin : g_en_neg
    assign en_out = ~en_act;
  end

  assign int_n = ~irq_act;

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
  parameter int BLANK_MS   = 512,
  parameter int LOCK_MS    = 64,
  parameter int INT_MIN_MS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic pb_low,
  input logic uv_low,
  input logic en_act,
  input logic int_n
);

  localparam int BW = $clog2(BLANK_MS + 1);
  localparam int LW = $clog2(LOCK_MS + 1);
  localparam int IW = $clog2(INT_MIN_MS + 1);
  localparam logic [BW-1:0] B_SAT = BW'(BLANK_MS);
  localparam logic [LW-1:0] L_SAT = LW'(LOCK_MS);
  localparam logic [IW-1:0] I_SAT = IW'(INT_MIN_MS);

  logic [BW-1:0] on_ms;
  logic [LW-1:0] off_ms;
  logic [IW-1:0] irq_ms;
  logic          was_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_ms  <= '0;
      off_ms <= '0;
      irq_ms <= '0;
      was_on <= 1'b0;
    end else begin
      if (!en_act)                      on_ms <= '0;
      else if (ms_tick && on_ms != B_SAT) on_ms <= on_ms + 1'b1;
      if (en_act)                        off_ms <= '0;
      else if (ms_tick && off_ms != L_SAT) off_ms <= off_ms + 1'b1;
      if (int_n)                         irq_ms <= '0;
      else if (ms_tick && irq_ms != I_SAT) irq_ms <= irq_ms + 1'b1;
      if (en_act) was_on <= 1'b1;
    end
  end

  p_on_needs_press_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_act) |-> $past(pb_low));

  p_on_blocked_by_uv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_act) |-> !$past(uv_low));

  p_blank_holds_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_act && on_ms < BW'(BLANK_MS - 1)) |=> en_act);

  p_int_needs_power_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> en_act);

  p_int_min_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_n) && en_act) |-> (irq_ms >= I_SAT));

  p_release_together_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_act) |-> int_n);

  p_lockout_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (was_on && !en_act && off_ms < L_SAT) |=> !en_act);

endmodule

bind pbc_top pbc_checker #(
  .BLANK_MS   (BLANK_MS),
  .LOCK_MS    (LOCK_MS),
  .INT_MIN_MS (INT_MIN_MS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ms_tick (ms_tick),
  .pb_low  (pb_low),
  .uv_low  (uv_low),
  .en_act  (en_act),
  .int_n   (int_n)
);

// File: tb/tb_pbc_top.sv
module tb_pbc_top;

  localparam int PS    = 4;
  localparam int DEB   = 4;
  localparam int BLK   = 8;
  localparam int FIX   = 10;
  localparam int LCK   = 4;
  localparam int IMIN  = 4;
  localparam int PDTC  = 3;
  localparam int IDLE  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic pb_n, uv_n, kill_n, pdt_tick;
  logic en_hi, en_lo, irq_hi, irq_lo;
  logic pdt_en;
  logic done = 1'b0;
  int   checks = 0;
  int   errors = 0;
  int   pdt_ph = 0;

  always #10 clk = ~clk;

  pbc_top #(
    .PRESCALE(PS), .DEB_MS(DEB), .BLANK_MS(BLK), .FIXED_MS(FIX), .LOCK_MS(LCK),
    .INT_MIN_MS(IMIN), .PDT_CYCLES(PDTC), .PDT_IDLE_MS(IDLE), .EN_ACTIVE_HIGH(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pb_n(pb_n), .uv_n(uv_n), .kill_n(kill_n),
    .pdt_tick(pdt_tick), .en_out(en_hi), .int_n(irq_hi)
  );

  pbc_top #(
    .PRESCALE(PS), .DEB_MS(DEB), .BLANK_MS(BLK), .FIXED_MS(FIX), .LOCK_MS(LCK),
    .INT_MIN_MS(IMIN), .PDT_CYCLES(PDTC), .PDT_IDLE_MS(IDLE), .EN_ACTIVE_HIGH(1'b0)
  ) dut_inv (
    .clk(clk), .rst_n(rst_n), .pb_n(pb_n), .uv_n(uv_n), .kill_n(kill_n),
    .pdt_tick(pdt_tick), .en_out(en_lo), .int_n(irq_lo)
  );

  initial begin
    pdt_tick = 1'b0;
    forever begin
      @(negedge clk);
      pdt_ph   = (pdt_ph + 1) % 8;
      pdt_tick = pdt_en && (pdt_ph == 0);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ms(input int n);
    wait_clk(n * PS);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_en(input string tag, input logic exp);
    check(tag, en_hi, exp);
    check("R13 inverted enable instance", en_lo, ~exp);
  endtask

  task automatic check_int(input string tag, input logic exp);
    check(tag, irq_hi, exp);
  endtask

  // Turn on with kill held high after enable; ends in the running state.
  task automatic power_on();
    pb_n = 1'b0;
    wait_ms(DEB + 2);
    check_en("R2 power on after debounce", 1'b1);
    pb_n = 1'b1;
    wait_ms(BLK + 2);
    check_en("R5 kill high keeps power after blanking", 1'b1);
  endtask

  initial begin
    rst_n  = 1'b0;
    pb_n   = 1'b1;
    uv_n   = 1'b1;
    kill_n = 1'b0;
    pdt_en = 1'b1;
    wait_clk(3);
    rst_n = 1'b1;
    wait_ms(2);

    // R1 reset state
    check_en("R1 enable inactive after reset", 1'b0);
    check_int("R1 interrupt idle after reset", 1'b1);

    // R2 short press ignored
    pb_n = 1'b0;
    wait_ms(2);
    pb_n = 1'b1;
    wait_ms(6);
    check_en("R2 short press ignored", 1'b0);

    // R3 undervoltage lockout of power-on
    uv_n = 1'b0;
    wait_ms(1);
    pb_n = 1'b0;
    wait_ms(8);
    check_en("R3 press ignored under undervoltage", 1'b0);
    pb_n = 1'b1;
    uv_n = 1'b1;
    wait_ms(2);

    // R2, R4, R5 abort: kill left low during blanking
    pb_n = 1'b0;
    wait_ms(2);
    check_en("R2 not on before debounce ends", 1'b0);
    wait_ms(4);
    check_en("R2 on after full debounce", 1'b1);
    pb_n = 1'b1;
    uv_n = 1'b0;
    wait_ms(2);
    uv_n = 1'b1;
    pb_n = 1'b0;
    check_en("R4 undervoltage ignored in blanking", 1'b1);
    check_int("R4 no interrupt in blanking", 1'b1);
    wait_ms(2);
    pb_n = 1'b1;
    wait_ms(1);
    check_en("R4 kill and button ignored in blanking", 1'b1);
    check_int("R4 interrupt idle in blanking", 1'b1);
    wait_ms(4);
    check_en("R5 abort when kill low at blanking end", 1'b0);

    // R12 press held across lockout must not restart power
    pb_n = 1'b0;
    wait_ms(8);
    check_en("R12 held press across lockout ignored", 1'b0);
    pb_n = 1'b1;
    wait_ms(3);

    // normal power on, kill raised during blanking
    pb_n = 1'b0;
    wait_ms(DEB + 2);
    check_en("R2 power on again after release", 1'b1);
    pb_n   = 1'b1;
    kill_n = 1'b1;
    wait_ms(BLK + 2);
    check_en("R5 kill high keeps power", 1'b1);

    // R7 and R8: short interrupt press, released mid-interrupt
    pb_n = 1'b0;
    wait_ms(3);
    check_int("R7 no interrupt before debounce", 1'b1);
    wait_ms(3);
    check_int("R7 interrupt after button debounce", 1'b0);
    check_en("R7 power kept during interrupt", 1'b1);
    pb_n = 1'b1;
    wait_clk(6);
    check_int("R8 interrupt held to minimum width", 1'b0);
    wait_clk(14);
    check_int("R8 interrupt released after minimum", 1'b1);
    check_en("R10 short press does not force off", 1'b1);

    // R6 kill while interrupt pending
    pb_n = 1'b0;
    wait_ms(6);
    check_int("R7 interrupt while held", 1'b0);
    kill_n = 1'b0;
    wait_ms(1);
    check_en("R6 kill releases enable during interrupt", 1'b0);
    check_int("R6 interrupt released with enable", 1'b1);
    pb_n = 1'b1;
    wait_ms(2);
    kill_n = 1'b1;
    wait_ms(6);

    // R6 kill in plain running state
    power_on();
    kill_n = 1'b0;
    wait_ms(1);
    check_en("R6 kill releases enable while running", 1'b0);
    kill_n = 1'b1;
    wait_ms(6);

    // R9 ownership: undervoltage falls while button owns
    power_on();
    pb_n = 1'b0;
    wait_ms(1);
    uv_n = 1'b0;
    wait_ms(5);
    pb_n = 1'b1;
    wait_ms(15);
    check_en("R9 undervoltage not timed while button owned", 1'b1);
    check_int("R7 undervoltage starts own interrupt", 1'b0);
    wait_ms(9);
    check_en("R10 undervoltage hold forces power off", 1'b0);
    check_int("R10 interrupt released with enable", 1'b1);
    uv_n = 1'b1;
    wait_ms(6);

    // R10 forced off by button with timer strobes
    power_on();
    pb_n = 1'b0;
    wait_ms(13);
    check_en("R10 not forced before strobes counted", 1'b1);
    check_int("R7 interrupt stays low while held", 1'b0);
    wait_ms(6);
    check_en("R10 forced off after fixed plus strobes", 1'b0);
    check_int("R10 interrupt released at forced off", 1'b1);
    pb_n = 1'b1;
    wait_ms(6);

    // R11 absent timer strobe: fixed delay alone
    pdt_en = 1'b0;
    wait_ms(6);
    power_on();
    pb_n = 1'b0;
    wait_clk(34);
    check_en("R11 not off before fixed delay", 1'b1);
    wait_clk(14);
    check_en("R11 off after fixed delay without strobes", 1'b0);
    pb_n = 1'b1;
    pdt_en = 1'b1;
    wait_ms(2);
    check_int("R1 interrupt idle at end", 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule